// File: doc/BRIEF.md
# VGA Sync Timing Sequencer

This block produces the horizontal and vertical synchronization levels for a 640x480 raster. A pixel-rate clock enable (25 MHz in the usual arrangement) advances a horizontal sequencer by one pixel position per enabled clock. That sequencer walks through the visible pixels, the front porch, the sync pulse and the back porch of each line. At the end of each line it issues a single-cycle wrap pulse. A separate vertical sequencer advances only on that pulse and walks through the same four kinds of phase, counted in lines.

The two sequencers are coupled only by the wrap pulse. A small event stage turns the start of each visible line into a one-clock `line_start` pulse, which tells a downstream pixel unit to begin shifting out a row. A `visible` flag marks the positions that lie inside the active picture. Every phase length is a parameter, so other resolutions use the same logic.

Top module: `vga_sync_seq`

## Requirements
- R1: The horizontal position advances by exactly one per clock in which `pix_en` is 1. While `pix_en` is 0, `hsync`, `vsync` and `visible` hold their values and `line_start` is 0.
- R2: A synchronous active-high `rst` has priority over `pix_en`. It places the raster at pixel 0 of line 0. In the cycle after reset: `hsync` = 1, `vsync` = 1, `visible` = 1, `line_start` = 0.
- R3: A line is 800 positions long. Positions 0–639 are active, 640–655 are the front porch, 656–751 have `hsync` = 0, and 752–799 are the back porch. Position 799 wraps to 0. `hsync` is 1 everywhere except the sync positions.
- R4: The line index advances only on the step from position 799 to position 0. A frame is 525 lines long. Lines 0–479 are active, 480–489 are the front porch, 490–491 have `vsync` = 0, and 492–524 are the back porch. Line 524 wraps to line 0. `vsync` is 1 everywhere except the sync lines.
- R5: `vsync` changes only together with a line wrap, so at every `vsync` edge `hsync` is 1.
- R6: `line_start` is 1 for exactly one clock. That clock is the one after the enabled step that enters pixel 0 of a line whose index is below 480. It includes the step that wraps from line 524 to line 0. Reset itself produces no pulse.
- R7: `visible` is 1 exactly when the pixel is below 640 and the line is below 480. Whenever `visible` is 1, both `hsync` and `vsync` are 1.
- R8: With any positive phase lengths set through the parameters, the same sequence holds using those lengths in place of the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel-rate step enable |
| hsync | output | 1 | Horizontal sync level, low during the line sync pulse |
| vsync | output | 1 | Vertical sync level, low during the frame sync pulse |
| line_start | output | 1 | One-clock pulse at the start of each visible row |
| visible | output | 1 | High inside the active picture area |

## Verification
Two instances share the same stimulus. The default one checks every horizontal boundary over many lines. A second one keeps the default vertical lengths but uses a 15-position line, so that several complete frames can be walked through. A pseudo-random enable pattern with gaps separates "advance once per enabled clock" from "advance once per clock". Long stretches with the enable held low show that the outputs hold and that no spurious row pulse appears. A reset in the middle of a frame, with the enable held high, followed by a fully enabled burst, shows that reset wins over a step and that the first row pulse comes only at the next line entry.

// File: rtl/vga_seq_pkg.sv
`timescale 1ns/1ps
package vga_seq_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_FRONT  = 2'd1,
    PH_SYNC   = 2'd2,
    PH_BACK   = 2'd3
  } phase_e;

  localparam int unsigned DEF_H_ACT = 640;
  localparam int unsigned DEF_H_FP  = 16;
  localparam int unsigned DEF_H_SY  = 96;
  localparam int unsigned DEF_H_BP  = 48;
  localparam int unsigned DEF_V_ACT = 480;
  localparam int unsigned DEF_V_FP  = 10;
  localparam int unsigned DEF_V_SY  = 2;
  localparam int unsigned DEF_V_BP  = 33;

endpackage

// File: rtl/vga_phase_seq.sv
`timescale 1ns/1ps
module vga_phase_seq
  import vga_seq_pkg::*;
#(
  parameter int unsigned LEN_ACT = 640,
  parameter int unsigned LEN_FP  = 16,
  parameter int unsigned LEN_SY  = 96,
  parameter int unsigned LEN_BP  = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic sync_n,
  output logic active,
  output logic wrap
);

  localparam int unsigned MAX_AF  = (LEN_ACT > LEN_FP) ? LEN_ACT : LEN_FP;
  localparam int unsigned MAX_SB  = (LEN_SY > LEN_BP) ? LEN_SY : LEN_BP;
  localparam int unsigned MAX_LEN = (MAX_AF > MAX_SB) ? MAX_AF : MAX_SB;
  localparam int unsigned CW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  function automatic logic [CW-1:0] last_of(input phase_e ph);
    case (ph)
      PH_ACTIVE: last_of = CW'(LEN_ACT - 1);
      PH_FRONT:  last_of = CW'(LEN_FP - 1);
      PH_SYNC:   last_of = CW'(LEN_SY - 1);
      default:   last_of = CW'(LEN_BP - 1);
    endcase
  endfunction

  always_comb begin
    at_last = (cnt_q == last_of(phase_q));
    phase_d = phase_q;
    cnt_d   = cnt_q + CW'(1);
    if (at_last) begin
      cnt_d = '0;
      case (phase_q)
        PH_ACTIVE: phase_d = PH_FRONT;
        PH_FRONT:  phase_d = PH_SYNC;
        PH_SYNC:   phase_d = PH_BACK;
        default:   phase_d = PH_ACTIVE;
      endcase
    end
  end

  assign wrap = adv && (phase_q == PH_BACK) && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ACTIVE;
      cnt_q   <= '0;
      sync_n  <= 1'b1;
      active  <= 1'b1;
    end else if (adv) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sync_n  <= (phase_d != PH_SYNC);
      active  <= (phase_d == PH_ACTIVE);
    end
  end

endmodule

// File: rtl/vga_row_event.sv
`timescale 1ns/1ps
module vga_row_event (
  input  logic clk,
  input  logic rst,
  input  logic line_wrap,
  input  logic row_active,
  output logic row_start
);

  logic wrap_d;

  always_ff @(posedge clk) begin
    if (rst) wrap_d <= 1'b0;
    else     wrap_d <= line_wrap;
  end

  assign row_start = wrap_d && row_active;

endmodule

// File: rtl/vga_sync_seq.sv
`timescale 1ns/1ps
module vga_sync_seq
  import vga_seq_pkg::*;
#(
  parameter int unsigned H_ACT = DEF_H_ACT,
  parameter int unsigned H_FP  = DEF_H_FP,
  parameter int unsigned H_SY  = DEF_H_SY,
  parameter int unsigned H_BP  = DEF_H_BP,
  parameter int unsigned V_ACT = DEF_V_ACT,
  parameter int unsigned V_FP  = DEF_V_FP,
  parameter int unsigned V_SY  = DEF_V_SY,
  parameter int unsigned V_BP  = DEF_V_BP
) (
  input  logic clk,
  input  logic rst,
  input  logic pix_en,
  output logic hsync,
  output logic vsync,
  output logic line_start,
  output logic visible
);

  logic h_active, h_wrap;
  logic v_active, v_wrap;

  vga_phase_seq #(
    .LEN_ACT(H_ACT), .LEN_FP(H_FP), .LEN_SY(H_SY), .LEN_BP(H_BP)
  ) u_hseq (
    .clk(clk), .rst(rst), .adv(pix_en),
    .sync_n(hsync), .active(h_active), .wrap(h_wrap)
  );

  vga_phase_seq #(
    .LEN_ACT(V_ACT), .LEN_FP(V_FP), .LEN_SY(V_SY), .LEN_BP(V_BP)
  ) u_vseq (
    .clk(clk), .rst(rst), .adv(h_wrap),
    .sync_n(vsync), .active(v_active), .wrap(v_wrap)
  );

  vga_row_event u_row (
    .clk(clk), .rst(rst), .line_wrap(h_wrap),
    .row_active(v_active), .row_start(line_start)
  );

  assign visible = h_active && v_active;

endmodule

// File: rtl/vga_sync_seq_chk.sv
`timescale 1ns/1ps
module vga_sync_seq_chk (
  input logic clk,
  input logic rst,
  input logic pix_en,
  input logic hsync,
  input logic vsync,
  input logic line_start,
  input logic visible,
  input logic v_wrap
);

  logic rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      p_reset_idle_r2: assert (hsync && vsync && visible && !line_start)
        else $error("R2: outputs not at reset values");
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(hsync) && $stable(vsync) && $stable(visible)));

  p_no_start_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!pix_en && !line_start) |=> !line_start);

  p_vsync_edge_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(vsync) |-> hsync);

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);

  p_frame_row_r6: assert property (@(posedge clk) disable iff (rst)
    v_wrap |=> line_start);

  p_start_visible_r6: assert property (@(posedge clk) disable iff (rst)
    line_start |-> visible);

  p_visible_sync_r7: assert property (@(posedge clk) disable iff (rst)
    visible |-> (hsync && vsync));

endmodule

bind vga_sync_seq vga_sync_seq_chk u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .hsync(hsync), .vsync(vsync),
  .line_start(line_start), .visible(visible), .v_wrap(v_wrap)
);

// File: tb/vga_sync_seq_tb.sv
`timescale 1ns/1ps
module vga_sync_seq_tb;

  localparam int HA = 640, HF = 16, HS = 96, HB = 48;
  localparam int SA = 8, SF = 2, SS = 3, SB = 2;
  localparam int VA = 480, VF = 10, VS = 2, VB = 33;
  localparam int HT = HA + HF + HS + HB;
  localparam int ST = SA + SF + SS + SB;
  localparam int VT = VA + VF + VS + VB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic hs0, vs0, ls0, vis0;
  logic hs1, vs1, ls1, vis1;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int p0 = 0, l0 = 0, p1 = 0, l1 = 0;
  bit ls0_exp = 1'b0, ls1_exp = 1'b0;
  logic vs0_prev = 1'b1, vs1_prev = 1'b1;

  always #5 clk = ~clk;

  vga_sync_seq u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .hsync(hs0), .vsync(vs0), .line_start(ls0), .visible(vis0)
  );

  vga_sync_seq #(
    .H_ACT(SA), .H_FP(SF), .H_SY(SS), .H_BP(SB)
  ) u_dut_short (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .hsync(hs1), .vsync(vs1), .line_start(ls1), .visible(vis1)
  );

  function automatic bit sync_lvl(int pos, int act, int fp, int sy);
    return !((pos >= act + fp) && (pos < act + fp + sy));
  endfunction

  task automatic cmp(string tag, string what, logic act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit en);
    string t0, t1, t2, t3;
    rst = r;
    pix_en = en;
    @(posedge clk);
    if (r) begin
      p0 = 0; l0 = 0; p1 = 0; l1 = 0; ls0_exp = 0; ls1_exp = 0;
    end else if (en) begin
      ls0_exp = 0; ls1_exp = 0;
      p0++;
      if (p0 == HT) begin
        p0 = 0; l0 = (l0 + 1) % VT; ls0_exp = (l0 < VA);
      end
      p1++;
      if (p1 == ST) begin
        p1 = 0; l1 = (l1 + 1) % VT; ls1_exp = (l1 < VA);
      end
    end else begin
      ls0_exp = 0; ls1_exp = 0;
    end
    @(negedge clk);
    t0 = r ? "R2" : (en ? "R3" : "R1");
    t1 = r ? "R2" : (en ? "R4" : "R1");
    t2 = r ? "R2" : (en ? "R6" : "R1");
    t3 = r ? "R2" : (en ? "R7" : "R1");
    cmp(t0, "hsync", hs0, sync_lvl(p0, HA, HF, HS));
    cmp(t1, "vsync", vs0, sync_lvl(l0, VA, VF, VS));
    cmp(t2, "line_start", ls0, ls0_exp);
    cmp(t3, "visible", vis0, (p0 < HA) && (l0 < VA));
    cmp("R8", "short hsync", hs1, sync_lvl(p1, SA, SF, SS));
    cmp("R8", "short vsync", vs1, sync_lvl(l1, VA, VF, VS));
    cmp("R8", "short line_start", ls1, ls1_exp);
    cmp("R8", "short visible", vis1, (p1 < SA) && (l1 < VA));
    if (!r) begin
      if (vs1 !== vs1_prev) cmp("R5", "hsync at vsync edge", hs1, 1'b1);
      if (vs0 !== vs0_prev) cmp("R5", "hsync at vsync edge", hs0, 1'b1);
    end
    vs0_prev = vs0;
    vs1_prev = vs1;
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 20000; i++) step(1'b0, ($urandom % 8) != 0);
    for (int i = 0; i < 60; i++) step(1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 2000; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule